// File: doc/BRIEF.md
# CAN Interrupt Priority Coder

This block collects the interrupt events of a CAN controller that has fifteen message buffers and one error source. Every event pulse sets a pending flag that holds until software clears it. Software writes one to a bit of the clear word to clear that flag. Each source has an interrupt enable bit. A second mask, the code-enable word, chooses which sources take part in coding.

From the sources that are pending, enabled and code-enabled, the block gives out a request bit and a 4-bit code that names the source with the highest priority. An interrupt handler can use the code directly as a jump displacement. Software can also change the code-enable word between passes, for example to serve all receive buffers first and then all transmit buffers.

Source bit mapping, used on every word and on `src_evt`: bit 0 is the error source, and bit n+1 is message buffer n.

Top module: `can_irq_coder`

## Requirements
- R1: After reset, all pending flags and all enable bits are 0, all code-enable bits are 1, `irq_req` is 0 and `irq_code` is 0.
- R2: A high `src_evt` bit sets its pending flag at the next clock edge. The flag then stays set with no further event. Pending flags can be read at address 3.
- R3: Writing to address 1 (clear) clears every pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R5: Reading address 1 returns zero. Reading address 0 returns the enable word, and reading address 2 returns the code-enable word. Read data is registered and appears one clock after `rd_addr` is presented.
- R6: When no source is pending, enabled and code-enabled, `irq_req` is 0 and `irq_code` is 0000.
- R7: When the error source (bit 0) qualifies, `irq_req` is 1 and `irq_code` is 0000.
- R8: When buffer n qualifies and no higher-priority source does, `irq_req` is 1 and `irq_code` is n+1. Buffer 0 gives 0001 and buffer 14 gives 1111.
- R9: Priority is fixed. The error source is highest, then buffer 0, and priority falls as the buffer number rises (lowest bit index wins).
- R10: A pending source whose enable bit (address 0) is 0 is not coded, and its pending flag is kept.
- R11: Only sources whose code-enable bit (address 2) is 1 are coded. The outputs follow a new code-enable value in the same cycle the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | Event pulses, bit 0 error, bit n+1 buffer n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 clear, 2 code-enable |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 enable, 1 clear, 2 code-enable, 3 pending |
| rd_data | output | 16 | Registered read data |
| irq_req | output | 1 | A qualifying source exists |
| irq_code | output | 4 | Index of the highest-priority qualifying source |

## Verification
The bench builds the block with its default fifteen buffers, which gives a 16-bit qualifier. At that size an exhaustive sweep is affordable. With every flag pending and every source enabled, the bench walks all 65536 code-enable words and checks request and code against the lowest set bit computed arithmetically. Strided sweeps of the enable word and of pending patterns (built from events and clears) cover the other two inputs to the qualifier. Directed cases cover reset, the event/clear collision and the read-back of the clear word.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  typedef enum logic [1:0] {
    SEL_ENA = 2'd0,
    SEL_CLR = 2'd1,
    SEL_CEN = 2'd2,
    SEL_PND = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/can_irq_cfg.sv
// Plain configuration word written through the register port.
module can_irq_cfg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RST_VAL;
    else if (load) q <= din;
  end
endmodule

// File: rtl/can_irq_flags.sv
// Pending flags: set by event, cleared by write-one; event wins a collision.
module can_irq_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  for (genvar g = 0; g < W; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[g] <= 1'b0;
      else if (set_vec[g]) flags[g] <= 1'b1;
      else if (clr_vec[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/can_irq_prio.sv
// Fixed-priority encoder: lowest set index wins.
module can_irq_prio #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  req_vec,
  output logic          found,
  output logic [CW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/can_irq_coder.sv
module can_irq_coder
  import can_irq_pkg::*;
#(
  parameter int NUM_BUF = 15,
  localparam int NSRC   = NUM_BUF + 1,
  localparam int CODE_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic [1:0]        rd_addr,
  output logic [NSRC-1:0]   rd_data,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code
);
  logic [NSRC-1:0] ena_q, cen_q, pend_q, clr_vec, qual;
  logic            ld_ena, ld_cen;

  assign ld_ena  = wr_en && (reg_sel_e'(wr_addr) == SEL_ENA);
  assign ld_cen  = wr_en && (reg_sel_e'(wr_addr) == SEL_CEN);
  assign clr_vec = (wr_en && (reg_sel_e'(wr_addr) == SEL_CLR)) ? wr_data : '0;

  can_irq_cfg #(.W(NSRC), .RST_VAL('0)) u_ena (
    .clk(clk), .rst(rst), .load(ld_ena), .din(wr_data), .q(ena_q)
  );

  can_irq_cfg #(.W(NSRC), .RST_VAL({NSRC{1'b1}})) u_cen (
    .clk(clk), .rst(rst), .load(ld_cen), .din(wr_data), .q(cen_q)
  );

  can_irq_flags #(.W(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set_vec(src_evt), .clr_vec(clr_vec), .flags(pend_q)
  );

  assign qual = pend_q & ena_q & cen_q;

  can_irq_prio #(.W(NSRC), .CW(CODE_W)) u_prio (
    .req_vec(qual), .found(irq_req), .idx(irq_code)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_addr))
        SEL_ENA: rd_data <= ena_q;
        SEL_CEN: rd_data <= cen_q;
        SEL_PND: rd_data <= pend_q;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/can_irq_coder_chk.sv
module can_irq_coder_chk #(
  parameter int NSRC   = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_evt,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [NSRC-1:0]   wr_data,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   ena_q,
  input logic [NSRC-1:0]   cen_q,
  input logic              irq_req,
  input logic [CODE_W-1:0] irq_code
);
  logic [NSRC-1:0] q_vec, below;
  assign q_vec = pend_q & ena_q & cen_q;
  assign below = (NSRC'(1) << irq_code) - NSRC'(1);

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_code == '0));  // R6
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));  // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_evt)) == '0));  // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> ((pend_q & $past(wr_data & ~src_evt)) == '0));  // R3
  AST_CODE_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> q_vec[irq_code]);  // R11
  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((q_vec & below) == '0));  // R9
endmodule

bind can_irq_coder can_irq_coder_chk #(.NSRC(NSRC), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .src_evt(src_evt), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pend_q(pend_q), .ena_q(ena_q), .cen_q(cen_q),
  .irq_req(irq_req), .irq_code(irq_code)
);

// File: tb/sim_can_irq_coder.sv
`timescale 1ns/1ps
module sim_can_irq_coder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_req;
  logic [3:0]  irq_code;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  can_irq_coder u0 (
    .clk(clk), .rst(rst), .src_evt(src_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    src_evt = v;
    @(posedge clk); #1;
    src_evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  // expected coder output from the qualifier word
  task automatic chk_code(input string rq, input logic [15:0] q);
    logic       e_req = 1'b0;
    logic [3:0] e_code = '0;
    for (int i = 15; i >= 0; i--) if (q[i]) begin e_req = 1'b1; e_code = 4'(i); end
    chk(rq, {31'd0, irq_req}, {31'd0, e_req});
    chk(rq, {28'd0, irq_code}, {28'd0, e_code});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 req", {31'd0, irq_req}, 0);
    chk("R1 code", {28'd0, irq_code}, 0);
    rd(2'd3, d); chk("R1 pend", {16'd0, d}, 0);
    rd(2'd0, d); chk("R1 ena", {16'd0, d}, 0);
    rd(2'd2, d); chk("R1 cen", {16'd0, d}, 32'hFFFF);
    // R2 event sets flag, R10 not coded while disabled
    pulse(16'h0010);
    rd(2'd3, d); chk("R2 pend", {16'd0, d}, 32'h0010);
    chk("R10 disabled req", {31'd0, irq_req}, 0);
    // R3 write zero no effect, write one clears
    wr(2'd1, 16'hFFEF);
    rd(2'd3, d); chk("R3 zero keeps", {16'd0, d}, 32'h0010);
    wr(2'd1, 16'h0010);
    rd(2'd3, d); chk("R3 cleared", {16'd0, d}, 0);
    // R4 collision: event wins
    @(negedge clk);
    src_evt = 16'h0100; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0100;
    @(posedge clk); #1;
    src_evt = '0; wr_en = 1'b0;
    rd(2'd3, d); chk("R4 collision", {16'd0, d}, 32'h0100);
    // R5 clear reads zero; enable read-back
    rd(2'd1, d); chk("R5 clr read", {16'd0, d}, 0);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R5 ena read", {16'd0, d}, 32'hFFFF);
    // R7 error source
    wr(2'd1, 16'hFFFF);
    pulse(16'h0001);
    chk_code("R7 error", 16'h0001);
    // R8 each single buffer, R6 empty
    for (int n = 0; n < 15; n++) begin
      wr(2'd1, 16'hFFFF);
      pulse(16'(1) << (n + 1));
      chk("R8 req", {31'd0, irq_req}, 1);
      chk("R8 code", {28'd0, irq_code}, 32'(n + 1));
    end
    wr(2'd1, 16'hFFFF);
    chk_code("R6 empty", 16'h0000);
    // R11 exhaustive code-enable sweep, all pending and enabled
    pulse(16'hFFFF);
    for (int v = 0; v < 65536; v++) begin
      wr(2'd2, 16'(v));
      chk_code("R11 R9 cen sweep", 16'(v));
    end
    // R10 enable sweep with code-enable all ones
    wr(2'd2, 16'hFFFF);
    for (int v = 0; v < 65536; v += 7) begin
      wr(2'd0, 16'(v));
      chk_code("R10 R9 ena sweep", 16'(v));
    end
    rd(2'd3, d); chk("R10 pend kept", {16'd0, d}, 32'hFFFF);
    // R9 pending patterns via events and clears
    wr(2'd0, 16'hFFFF);
    for (int k = 0; k < 4096; k += 3) begin
      logic [15:0] p;
      p = 16'(k * 40503);
      pulse(16'hFFFF);
      wr(2'd1, ~p);
      chk_code("R9 R3 pend sweep", p);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule